// File: doc/BRIEF.md
# Single-Line Atomic Buffer

This block sits beside one bank of a shared second-level cache and serves atomic read-modify-write requests on 32-bit words. It keeps exactly one 32-byte line in local storage: the line touched by the most recent atomic. An atomic that falls in the held line runs on the local copy. It returns the word as it was before the operation. A stream of atomics to that line completes at one per clock, and no cache-bank traffic is needed for it.

When an atomic addresses a different line, the buffer stops accepting requests. If the held line was changed, it is written back to the bank first. The wanted line is then read in, and the waiting atomic runs on it. A flush input pushes a changed line back to the bank without evicting it. The cache bank itself lies outside the block. The block sees it only through a simple line-wide request/acknowledge port.

Top module: `atomic_line_buffer`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, l2Req is 0, and the buffer holds no line, so the first atomic always misses.
- R2: The operation codes on reqOp are 0 add, 1 unsigned minimum, 2 unsigned maximum, 3 exchange, 4 compare-and-swap, 5 and, 6 or and 7 xor. Compare-and-swap writes reqOperand only when the stored word equals reqCompare. Every response carries the pre-operation word on rspData and the request's reqId on rspId.
- R3: The held-line tag is reqAddr[ADDR_W-1:5] and the word within the line is reqAddr[4:2]. reqAddr[1:0] has no effect.
- R4: An atomic accepted on a hit gets its response in the cycle after acceptance. Hits accepted on consecutive cycles give responses on consecutive cycles, and each one sees the result of the one before it.
- R5: On a miss, reqReady stays 0 until the operation has finished. The new line is read from the bank (l2Req=1, l2Write=0, l2Addr equal to the new tag), and the atomic then runs on the fetched data.
- R6: On a miss, a held line that is dirty is written to the bank at its own tag before the refill. A held line that is clean or absent causes no write.
- R7: An operation marks the line dirty only when it changes the stored word. Operations that leave the word as it was keep a clean line clean.
- R8: flushReq is sampled while the buffer is idle. A dirty line is written back and stays held, now clean. With a clean line, a flush produces no bank traffic.
- R9: A bank request holds l2Req, l2Write and l2Addr steady until the cycle in which l2Ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Atomic request present |
| reqReady | output | 1 | Request accepted at this edge when reqValid is also 1 |
| reqOp | input | 3 | Operation code |
| reqAddr | input | ADDR_W | Byte address of the target word |
| reqOperand | input | 32 | Operand, or swap value for compare-and-swap |
| reqCompare | input | 32 | Compare value for compare-and-swap |
| reqId | input | ID_W | Request tag echoed in the response |
| flushReq | input | 1 | Request write-back of a dirty held line |
| rspValid | output | 1 | Response present for one cycle |
| rspData | output | 32 | Word value before the operation |
| rspId | output | ID_W | Tag of the answered request |
| l2Req | output | 1 | Bank access request |
| l2Write | output | 1 | 1 for write-back, 0 for line read |
| l2Addr | output | ADDR_W-5 | Line address of the bank access |
| l2WrLine | output | 256 | Line data for a write-back |
| l2Ack | input | 1 | Bank access complete; read data valid in this cycle |
| l2RdLine | input | 256 | Line data returned by a read |

## Verification
The bench targets the following corner cases and the faults each would reveal.
- Dependent hits issued back to back: a design that read a stale word would return old values one step behind the reference sum.
- Compare-and-swap, both matching and failing: a wrong comparison would corrupt the word or the response. Minimum and maximum use operands with the top bit set, so signed comparison would give the wrong winner.
- Eviction of a dirty line compared with eviction of a line touched only by value-preserving operations: a dirty bit that is set on every operation would show up as an extra bank write.
- Flushes of dirty and clean lines: the bench checks the bank contents and the access counts. A flush that dropped the line would cause a refill on the next access.

// File: rtl/alb_pkg.sv
package alb_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MINU = 3'd1,
    OP_MAXU = 3'd2,
    OP_XCHG = 3'd3,
    OP_CAS  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } alb_op_e;

  // Strobes from the sequencer to the line datapath
  typedef struct packed {
    logic latchReq;   // capture a missing request
    logic execIn;     // run the incoming request on the held line
    logic execPend;   // run the captured request on the refilled line
    logic loadFill;   // install the line returned by the bank
    logic markClean;  // write-back finished
    logic wbPhase;    // bank access uses the held tag
  } alb_ctl_t;

  function automatic logic [WORD_W-1:0] aluApply(alb_op_e op,
                                                 logic [WORD_W-1:0] oldW,
                                                 logic [WORD_W-1:0] opd,
                                                 logic [WORD_W-1:0] cmp);
    case (op)
      OP_ADD:  return oldW + opd;
      OP_MINU: return (opd < oldW) ? opd : oldW;
      OP_MAXU: return (opd > oldW) ? opd : oldW;
      OP_XCHG: return opd;
      OP_CAS:  return (oldW == cmp) ? opd : oldW;
      OP_AND:  return oldW & opd;
      OP_OR:   return oldW | opd;
      default: return oldW ^ opd;
    endcase
  endfunction

endpackage

// File: rtl/alb_ctrl.sv
module alb_ctrl
  import alb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     flushReq,
  input  logic     hit,
  input  logic     lineDirty,
  input  logic     l2Ack,
  output logic     reqReady,
  output logic     l2Req,
  output logic     l2Write,
  output alb_ctl_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL, ST_EXEC} st_e;

  st_e  state, stateNext;
  logic flushOnly, flushOnlyNext;

  always_comb begin
    stateNext     = state;
    flushOnlyNext = flushOnly;
    ctl           = '0;
    reqReady      = 1'b0;
    l2Req         = 1'b0;
    l2Write       = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = !flushReq;
        if (flushReq) begin
          if (lineDirty) begin
            stateNext     = ST_WBACK;
            flushOnlyNext = 1'b1;
          end
        end else if (reqValid) begin
          if (hit) begin
            ctl.execIn = 1'b1;
          end else begin
            ctl.latchReq  = 1'b1;
            flushOnlyNext = 1'b0;
            stateNext     = lineDirty ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        l2Req       = 1'b1;
        l2Write     = 1'b1;
        ctl.wbPhase = 1'b1;
        if (l2Ack) begin
          ctl.markClean = 1'b1;
          stateNext     = flushOnly ? ST_IDLE : ST_FILL;
        end
      end
      ST_FILL: begin
        l2Req = 1'b1;
        if (l2Ack) begin
          ctl.loadFill = 1'b1;
          stateNext    = ST_EXEC;
        end
      end
      default: begin
        ctl.execPend = 1'b1;
        stateNext    = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      flushOnly <= 1'b0;
    end else begin
      state     <= stateNext;
      flushOnly <= flushOnlyNext;
    end
  end

  // R8: a flush with a clean line starts no bank access
  a_r8_clean_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && flushReq && !lineDirty) |=> !l2Req);

  // R5: the refill is always followed by the deferred operation
  a_r5_fill_then_exec: assert property (@(posedge clk) disable iff (!rstN)
    (l2Req && !l2Write && l2Ack) |=> (ctl.execPend && !reqReady));

endmodule

// File: rtl/alb_datapath.sv
module alb_datapath
  import alb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int ID_W       = 4,
  localparam int WORDS     = LINE_BYTES / 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEL_W     = $clog2(WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  alb_ctl_t          ctl,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqOperand,
  input  logic [WORD_W-1:0] reqCompare,
  input  logic [ID_W-1:0]   reqId,
  input  logic [LINE_W-1:0] l2RdLine,
  output logic              hit,
  output logic              lineDirty,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic [ID_W-1:0]   rspId,
  output logic [TAG_W-1:0]  l2Addr,
  output logic [LINE_W-1:0] l2WrLine
);

  logic [WORDS-1:0][WORD_W-1:0] lineReg;
  logic [TAG_W-1:0]             tagReg;
  logic                         validReg;
  logic                         dirtyReg;

  logic [2:0]        pendOp;
  logic [TAG_W-1:0]  pendTag;
  logic [SEL_W-1:0]  pendSel;
  logic [WORD_W-1:0] pendOpd, pendCmp;
  logic [ID_W-1:0]   pendId;

  logic [TAG_W-1:0]  inTag;
  logic [SEL_W-1:0]  inSel;
  logic [1:0]        unusedAddrBits;

  logic [SEL_W-1:0]  exSel;
  logic [2:0]        exOp;
  logic [WORD_W-1:0] exOpd, exCmp, oldWord, newWord;
  logic [ID_W-1:0]   exId;
  logic              doExec;

  assign inTag          = reqAddr[ADDR_W-1:OFF_W];
  assign inSel          = reqAddr[OFF_W-1:2];
  assign unusedAddrBits = reqAddr[1:0];

  assign hit       = validReg && (tagReg == inTag);
  assign lineDirty = dirtyReg;
  assign l2Addr    = ctl.wbPhase ? tagReg : pendTag;
  assign l2WrLine  = lineReg;

  assign doExec  = ctl.execIn || ctl.execPend;
  assign exSel   = ctl.execPend ? pendSel : inSel;
  assign exOp    = ctl.execPend ? pendOp  : reqOp;
  assign exOpd   = ctl.execPend ? pendOpd : reqOperand;
  assign exCmp   = ctl.execPend ? pendCmp : reqCompare;
  assign exId    = ctl.execPend ? pendId  : reqId;
  assign oldWord = lineReg[exSel];
  assign newWord = aluApply(alb_op_e'(exOp), oldWord, exOpd, exCmp);

  always_ff @(posedge clk) begin
    if (ctl.latchReq) begin
      pendOp  <= reqOp;
      pendTag <= inTag;
      pendSel <= inSel;
      pendOpd <= reqOperand;
      pendCmp <= reqCompare;
      pendId  <= reqId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validReg <= 1'b0;
      dirtyReg <= 1'b0;
      tagReg   <= '0;
      lineReg  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      rspId    <= '0;
    end else begin
      rspValid <= doExec;
      if (ctl.markClean) dirtyReg <= 1'b0;
      if (ctl.loadFill) begin
        lineReg  <= l2RdLine;
        tagReg   <= pendTag;
        validReg <= 1'b1;
        dirtyReg <= 1'b0;
      end
      if (doExec) begin
        lineReg[exSel] <= newWord;
        if (newWord != oldWord) dirtyReg <= 1'b1;
        rspData <= oldWord;
        rspId   <= exId;
      end
    end
  end

  // R6: only a dirty line is ever written to the bank
  a_r6_wb_needs_dirty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wbPhase |-> (dirtyReg && validReg));

  // R5: an installed line carries the tag of the waiting request
  a_r5_fill_tag: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFill |=> (validReg && hit == (tagReg == inTag) && tagReg == pendTag));

  // R4: a hit is answered on the next cycle with its own tag
  a_r4_hit_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.execIn |=> (rspValid && rspId == $past(reqId)));

  // R7: an operation on a clean line that keeps the word keeps it clean
  a_r7_unchanged_clean: assert property (@(posedge clk) disable iff (!rstN)
    (doExec && !dirtyReg && !ctl.loadFill && newWord == oldWord) |=> !dirtyReg);

endmodule

// File: rtl/atomic_line_buffer.sv
module atomic_line_buffer
  import alb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int ID_W       = 4,
  localparam int TAG_W     = ADDR_W - $clog2(LINE_BYTES),
  localparam int LINE_W    = (LINE_BYTES / 4) * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqOperand,
  input  logic [31:0]       reqCompare,
  input  logic [ID_W-1:0]   reqId,
  input  logic              flushReq,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic [ID_W-1:0]   rspId,
  output logic              l2Req,
  output logic              l2Write,
  output logic [TAG_W-1:0]  l2Addr,
  output logic [LINE_W-1:0] l2WrLine,
  input  logic              l2Ack,
  input  logic [LINE_W-1:0] l2RdLine
);

  alb_ctl_t ctl;
  logic     hit;
  logic     lineDirty;

  alb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .flushReq  (flushReq),
    .hit       (hit),
    .lineDirty (lineDirty),
    .l2Ack     (l2Ack),
    .reqReady  (reqReady),
    .l2Req     (l2Req),
    .l2Write   (l2Write),
    .ctl       (ctl)
  );

  alb_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .ID_W       (ID_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqOperand (reqOperand),
    .reqCompare (reqCompare),
    .reqId      (reqId),
    .l2RdLine   (l2RdLine),
    .hit        (hit),
    .lineDirty  (lineDirty),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspId      (rspId),
    .l2Addr     (l2Addr),
    .l2WrLine   (l2WrLine)
  );

  // R9: a pending bank access keeps its command and address
  a_r9_l2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (l2Req && !l2Ack) |=> (l2Req && $stable(l2Write) && $stable(l2Addr)));

endmodule

// File: tb/atomic_line_buffer_bench.sv
`timescale 1ns/1ps
module atomic_line_buffer_bench;

  localparam int ADDR_W = 12;
  localparam int ID_W   = 4;
  localparam int TAG_W  = ADDR_W - 5;
  localparam int LINES  = 1 << TAG_W;
  localparam int NWORDS = LINES * 8;
  localparam int QD     = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [2:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqOperand = '0, reqCompare = '0;
  logic [ID_W-1:0]   reqId = '0;
  logic              flushReq = 1'b0;
  logic              rspValid;
  logic [31:0]       rspData;
  logic [ID_W-1:0]   rspId;
  logic              l2Req, l2Write, l2Ack;
  logic [TAG_W-1:0]  l2Addr;
  logic [255:0]      l2WrLine, l2RdLine;

  atomic_line_buffer u_atomic_line_buffer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqOperand(reqOperand),
    .reqCompare(reqCompare), .reqId(reqId), .flushReq(flushReq),
    .rspValid(rspValid), .rspData(rspData), .rspId(rspId),
    .l2Req(l2Req), .l2Write(l2Write), .l2Addr(l2Addr), .l2WrLine(l2WrLine),
    .l2Ack(l2Ack), .l2RdLine(l2RdLine)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int cycle   = 0;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [31:0] initVal(int w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Bank model
  logic [255:0] mem [LINES];
  int wrCount, rdCount;
  int dly;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      l2Ack   <= 1'b0;
      dly     <= 0;
      wrCount <= 0;
      rdCount <= 0;
      l2RdLine <= '0;
      for (int i = 0; i < LINES; i++)
        for (int j = 0; j < 8; j++) mem[i][j*32 +: 32] <= initVal(i*8 + j);
    end else begin
      l2Ack <= 1'b0;
      if (l2Req && !l2Ack) begin
        if (dly == 2) begin
          dly   <= 0;
          l2Ack <= 1'b1;
          if (l2Write) begin
            mem[l2Addr] <= l2WrLine;
            wrCount <= wrCount + 1;
          end else begin
            l2RdLine <= mem[l2Addr];
            rdCount <= rdCount + 1;
          end
        end else dly <= dly + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference memory and expected-response queue
  logic [31:0] gold [NWORDS];
  logic [31:0] expData [QD];
  logic [ID_W-1:0] expId [QD];
  int rspCyc [QD];
  int wrPtr = 0, rdPtr = 0;

  initial for (int w = 0; w < NWORDS; w++) gold[w] = initVal(w);

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] o,
                                        input logic [31:0] a, input logic [31:0] c);
    case (op)
      3'd0: return o + a;
      3'd1: return (a < o) ? a : o;
      3'd2: return (a > o) ? a : o;
      3'd3: return a;
      3'd4: return (o == c) ? a : o;
      3'd5: return o & a;
      3'd6: return o | a;
      default: return o ^ a;
    endcase
  endfunction

  // Response monitor (R2 data and tag)
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (rdPtr == wrPtr) chk("R2 unexpected response", 32'd1, 32'd0);
      else begin
        chk("R2 data", rspData, expData[rdPtr]);
        chk("R2 id", 32'(rspId), 32'(expId[rdPtr]));
        rspCyc[rdPtr] = cycle;
        rdPtr++;
      end
    end
  end

  // R9 observed at the port
  logic prevPend = 1'b0;
  logic prevWrite;
  logic [TAG_W-1:0] prevAddr;
  always @(negedge clk) begin
    if (rstN && prevPend) begin
      chk("R9 req held", 32'(l2Req), 32'd1);
      chk("R9 addr held", 32'(l2Addr), 32'(prevAddr));
      chk("R9 cmd held", 32'(l2Write), 32'(prevWrite));
    end
    prevPend  = rstN && l2Req && !l2Ack;
    prevAddr  = l2Addr;
    prevWrite = l2Write;
  end

  task automatic issue(input logic [2:0] op, input int addr, input logic [31:0] opd,
                       input logic [31:0] cmp);
    int w;
    w = addr >> 2;
    expData[wrPtr] = gold[w];
    expId[wrPtr]   = ID_W'(wrPtr);
    gold[w] = model(op, gold[w], opd, cmp);
    reqValid   = 1'b1;
    reqOp      = op;
    reqAddr    = ADDR_W'(addr);
    reqOperand = opd;
    reqCompare = cmp;
    reqId      = ID_W'(wrPtr);
    wrPtr++;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = 1'b0;
    while (rdPtr != wrPtr) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic flushPulse();
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic chkLine(input string tag, input int ln);
    for (int j = 0; j < 8; j++) chk(tag, mem[ln][j*32 +: 32], gold[ln*8 + j]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int w0, r0, first;
    logic [31:0] rng;
    rng = 32'h1357_9BDF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(reqReady), 32'd1);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 l2Req", 32'(l2Req), 32'd0);

    // R5/R6 first access misses an empty buffer: one read, no write
    issue(3'd0, 3*32 + 0, 32'd7, 32'd0);
    chk("R5 ready low during refill", 32'(reqReady), 32'd0);
    idle();
    chk("R5 refill read count", 32'(rdCount), 32'd1);
    chk("R6 no write for empty buffer", 32'(wrCount), 32'd0);

    // R2/R4 back-to-back dependent hits over every operation
    first = wrPtr;
    issue(3'd0, 3*32 + 4,  32'd5, 0);
    issue(3'd0, 3*32 + 4,  32'hFFFF_FFF0, 0);
    issue(3'd1, 3*32 + 8,  32'h8000_0001, 0);
    issue(3'd1, 3*32 + 8,  32'h0000_0003, 0);
    issue(3'd2, 3*32 + 12, 32'h9000_0000, 0);
    issue(3'd2, 3*32 + 12, 32'h0000_0001, 0);
    issue(3'd3, 3*32 + 16, 32'hCAFE_0001, 0);
    issue(3'd4, 3*32 + 16, 32'h1111_1111, 32'hCAFE_0001);
    issue(3'd4, 3*32 + 16, 32'h2222_2222, 32'hCAFE_0001);
    issue(3'd5, 3*32 + 24, 32'hF0F0_FF00, 0);
    issue(3'd6, 3*32 + 24, 32'h0000_000F, 0);
    issue(3'd7, 3*32 + 24, 32'hFFFF_0000, 0);
    issue(3'd7, 3*32 + 28, 32'h1234_5678, 0);
    issue(3'd0, 3*32 + 28, 32'd1, 0);
    // R3 low address bits are ignored
    issue(3'd0, 3*32 + 20 + 3, 32'd9, 0);
    issue(3'd3, 3*32 + 20 + 1, 32'd0, 0);
    idle();
    chk("R4 one per cycle", 32'(rspCyc[first+15] - rspCyc[first]), 32'd15);
    chk("R4 hits cause no refill", 32'(rdCount), 32'd1);

    // R6 dirty line written back on a miss
    issue(3'd0, 9*32, 32'd1, 0);
    idle();
    chk("R6 dirty write-back count", 32'(wrCount), 32'd1);
    chkLine("R6 written line contents", 3);

    // R7 value-preserving operations keep line 9 clean
    w0 = wrCount;
    issue(3'd1, 9*32 + 4,  32'hFFFF_FFFF, 0);
    issue(3'd2, 9*32 + 8,  32'd0, 0);
    issue(3'd5, 9*32 + 12, 32'hFFFF_FFFF, 0);
    issue(3'd6, 9*32 + 16, 32'd0, 0);
    issue(3'd7, 9*32 + 20, 32'd0, 0);
    issue(3'd4, 9*32 + 24, 32'd5, ~initVal(9*8 + 6));
    issue(3'd0, 9*32 + 28, 32'd0, 0);
    idle();
    // line 9 was dirtied by the add above; clear it with a flush first
    flushPulse();
    chk("R8 flush writes dirty line", 32'(wrCount), 32'(w0 + 1));
    chkLine("R8 flushed line contents", 9);
    w0 = wrCount;
    issue(3'd6, 9*32 + 4, 32'd0, 0);
    issue(3'd4, 9*32 + 8, 32'd1, ~gold[9*8 + 2]);
    idle();
    issue(3'd0, 12*32, 32'd3, 0);
    idle();
    chk("R7 clean line evicted without write", 32'(wrCount), 32'(w0));

    // R8 flush keeps line held; clean flush is silent
    issue(3'd0, 12*32 + 4, 32'd5, 0);
    idle();
    w0 = wrCount; r0 = rdCount;
    flushPulse();
    chk("R8 dirty flush write", 32'(wrCount), 32'(w0 + 1));
    chkLine("R8 flush data", 12);
    issue(3'd7, 12*32 + 8, 32'd0, 0);
    idle();
    chk("R8 line stays held", 32'(rdCount), 32'(r0));
    flushPulse();
    chk("R8 clean flush no write", 32'(wrCount), 32'(w0 + 1));
    chk("R8 clean flush no read", 32'(rdCount), 32'(r0));

    // Sweep: 16 lines, every word with every operation, streamed
    for (int ln = 0; ln < 16; ln++) begin
      int line;
      line = (ln * 37) % LINES;
      for (int k = 0; k < 64; k++) begin
        int word, addr;
        logic [31:0] cmp;
        word = k / 8;
        addr = line*32 + word*4 + (k % 4);
        rng = rng * 32'd1664525 + 32'd1013904223;
        cmp = k[3] ? gold[line*8 + word] : rng ^ 32'h00FF_00FF;
        issue(3'(k % 8), addr, rng, cmp);
      end
      if (ln % 4 == 3) begin
        issue(3'd0, 3*32, 32'd2, 0);
      end
    end
    idle();
    flushPulse();
    for (int i = 0; i < LINES; i++) chkLine("R6 final bank image", i);

    finishRun();
  end

endmodule